// File: doc/BRIEF.md
# Packed 4:2:2 Luma/Chroma to 24-bit RGB Stream Converter

This block sits in a display pipeline between a pixel source and the output stage. It accepts a stream of 16-bit words carrying luma and chroma in packed 4:2:2 form. Each word carries one luma sample and one chroma sample. The two chroma samples of a pixel pair arrive in alternate words, so two neighbouring pixels share one blue-difference and one red-difference value. The block rebuilds each pair once both chroma samples are present. It then converts each pixel to 8-bit red, green and blue using a fixed-point matrix with offset removal, rounding and saturation.

Both sides are valid/ready streams. A word moves on the input when `in_valid` and `in_ready` are both high at a rising clock edge. A pixel moves on the output when `out_valid` and `out_ready` are both high at a rising clock edge. Once `out_valid` is raised, it stays high and `out_data` stays unchanged until the pixel is taken. A stalled output backs up through every internal stage to `in_ready`, and no word or pixel is dropped or repeated. With the output always ready, the input takes one word per cycle without a break. The output then delivers one pixel per cycle.

Top module: `yuv422_rgb_conv`

## Requirements
- R1: The low byte `in_data[7:0]` of every input word is a luma sample and the high byte `in_data[15:8]` is a chroma sample. After reset the first accepted word carries the blue-difference sample (U), the next carries the red-difference sample (V), and this alternation continues. Each U word and the V word after it form a pair of pixels that both use that U and V.
- R2: Each output channel equals the floor of (298·(Y−16) + kU·(U−128) + kV·(V−128) + 128) / 256. The coefficients (kU, kV) are (0, 409) for red, (−100, −208) for green and (516, 0) for blue.
- R3: A channel result below 0 is output as 0, and a result above 255 is output as 255.
- R4: `out_data` packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Of a pair, the pixel using the luma of the U word comes out first, followed by the pixel using the luma of the V word.
- R5: No pixel of a pair appears at the output before the V word of that pair has been accepted.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. Under any pattern of back-pressure and input gaps, every pixel comes out exactly once and in order.
- R7: During and right after reset `out_valid` is low and `in_ready` is high. A word accepted before reset is discarded, and the next accepted word is treated as a U word.
- R8: With `out_ready` held high and words offered every cycle, `in_ready` never drops, so one word is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | 16 | Packed word: chroma in bits 15:8, luma in bits 7:0 |
| out_valid | output | 1 | Output pixel offered |
| out_ready | input | 1 | Downstream takes the pixel this cycle |
| out_data | output | 24 | RGB pixel: red 23:16, green 15:8, blue 7:0 |

## Verification
The bound checker checks on every cycle these properties:
- a stalled pixel is held steady;
- the output is idle right after reset;
- no pixel is offered before the V word of its pair has entered;
- the number of words taken but not yet delivered as pixels stays within the block's storage.

Only the bench scenarios can show whether the numbers themselves are right. They cover the matrix values, clamping at both ends of the range, the pixel order within a pair, and the U/V alternation restarting after reset. The scenarios also show the full one-word-per-cycle rate and the exact pixel sequence under heavy back-pressure with gaps in the input.

// File: rtl/yuv_csc_pkg.sv
package yuv_csc_pkg;
  localparam int PIX_W   = 8;
  localparam int WORD_W  = 2 * PIX_W;
  localparam int RGB_W   = 3 * PIX_W;
  localparam int FRAC_W  = 8;
  localparam int ACC_W   = PIX_W + FRAC_W + 4;
  localparam int NCH     = 3;

  localparam int LUMA_OFS   = 16 << (PIX_W - 8);
  localparam int CHROMA_OFS = 1 << (PIX_W - 1);
  localparam int ROUND_ADD  = 1 << (FRAC_W - 1);
  localparam int SAT_TOP    = (1 << PIX_W) - 1;

  // channel index: 0 red, 1 green, 2 blue
  localparam int K_LUMA = 298;
  localparam int K_CB [0:NCH-1] = '{0, -100, 516};
  localparam int K_CR [0:NCH-1] = '{409, -208, 0};

  typedef struct packed {
    logic [PIX_W-1:0] y0;
    logic [PIX_W-1:0] y1;
    logic [PIX_W-1:0] cb;
    logic [PIX_W-1:0] cr;
  } yuv_pair_t;

  typedef struct packed {
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] cb;
    logic [PIX_W-1:0] cr;
  } yuv_pix_t;
endpackage

// File: rtl/yuv_pair_gather.sv
module yuv_pair_gather
  import yuv_csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              pair_valid,
  input  logic              pair_ready,
  output yuv_pair_t         pair
);
  logic             cr_phase;
  logic [PIX_W-1:0] y0_q;
  logic [PIX_W-1:0] cb_q;
  logic             take;

  // a U word only fills the holding register; a V word needs the pair slot
  assign in_ready = !cr_phase || !pair_valid || pair_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_phase   <= 1'b0;
      pair_valid <= 1'b0;
    end else begin
      if (pair_valid && pair_ready)
        pair_valid <= 1'b0;
      if (take) begin
        cr_phase <= !cr_phase;
        if (cr_phase)
          pair_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take && !cr_phase) begin
      y0_q <= in_data[PIX_W-1:0];
      cb_q <= in_data[WORD_W-1:PIX_W];
    end
    if (take && cr_phase) begin
      pair.y0 <= y0_q;
      pair.y1 <= in_data[PIX_W-1:0];
      pair.cb <= cb_q;
      pair.cr <= in_data[WORD_W-1:PIX_W];
    end
  end
endmodule

// File: rtl/yuv_pixel_split.sv
module yuv_pixel_split
  import yuv_csc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pair_valid,
  output logic      pair_ready,
  input  yuv_pair_t pair,
  output logic      pix_valid,
  input  logic      pix_ready,
  output yuv_pix_t  pix
);
  logic second_q;

  assign pix_valid  = pair_valid;
  assign pix.y      = second_q ? pair.y1 : pair.y0;
  assign pix.cb     = pair.cb;
  assign pix.cr     = pair.cr;
  // the pair is released only when its second pixel leaves
  assign pair_ready = pix_ready && second_q;

  always_ff @(posedge clk) begin
    if (rst)
      second_q <= 1'b0;
    else if (pix_valid && pix_ready)
      second_q <= !second_q;
  end
endmodule

// File: rtl/yuv_csc_matrix.sv
module yuv_csc_matrix
  import yuv_csc_pkg::*;
(
  input  yuv_pix_t         pix,
  output logic [RGB_W-1:0] rgb
);
  localparam logic signed [ACC_W-1:0] KL  = ACC_W'(K_LUMA);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(ROUND_ADD);
  localparam logic signed [ACC_W-1:0] TOP = ACC_W'(SAT_TOP);

  logic signed [ACC_W-1:0] c_s;
  logic signed [ACC_W-1:0] d_s;
  logic signed [ACC_W-1:0] e_s;

  assign c_s = $signed(ACC_W'(pix.y))  - $signed(ACC_W'(LUMA_OFS));
  assign d_s = $signed(ACC_W'(pix.cb)) - $signed(ACC_W'(CHROMA_OFS));
  assign e_s = $signed(ACC_W'(pix.cr)) - $signed(ACC_W'(CHROMA_OFS));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam logic signed [ACC_W-1:0] KB = ACC_W'(K_CB[ch]);
    localparam logic signed [ACC_W-1:0] KR = ACC_W'(K_CR[ch]);
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] sh;

    assign sum = KL * c_s + KB * d_s + KR * e_s + RND;
    assign sh  = sum >>> FRAC_W;
    assign rgb[RGB_W-1-ch*PIX_W -: PIX_W] =
      (sh < 0)   ? '0 :
      (sh > TOP) ? {PIX_W{1'b1}} : sh[PIX_W-1:0];
  end
endmodule

// File: rtl/yuv422_rgb_conv.sv
module yuv422_rgb_conv
  import yuv_csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_data
);
  yuv_pair_t        pair;
  logic             pair_valid;
  logic             pair_ready;
  yuv_pix_t         pix;
  logic             pix_valid;
  logic             pix_ready;
  logic [RGB_W-1:0] rgb;

  yuv_pair_gather u_gather (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .pair       (pair)
  );

  yuv_pixel_split u_split (
    .clk        (clk),
    .rst        (rst),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .pair       (pair),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix        (pix)
  );

  yuv_csc_matrix u_matrix (
    .pix (pix),
    .rgb (rgb)
  );

  assign pix_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)
      out_valid <= 1'b0;
    else if (pix_ready)
      out_valid <= pix_valid;
  end

  always_ff @(posedge clk) begin
    if (pix_ready && pix_valid)
      out_data <= rgb;
  end
endmodule

// File: rtl/yuv422_rgb_conv_chk.sv
module yuv422_rgb_conv_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_data
);
  logic [31:0] words_in;
  logic [31:0] pix_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      words_in <= '0;
      pix_out  <= '0;
    end else begin
      if (in_valid && in_ready)
        words_in <= words_in + 32'd1;
      if (out_valid && out_ready)
        pix_out <= pix_out + 32'd1;
    end
  end

  p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5: a pixel offered must belong to a pair whose V word is in
  p_v_before_pixel_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pix_out < {words_in[31:1], 1'b0}));

  // R6: storage holds at most four words' worth of pending pixels
  p_occupancy_r6: assert property (@(posedge clk) disable iff (rst)
    (words_in - pix_out) <= 32'd4);
endmodule

bind yuv422_rgb_conv yuv422_rgb_conv_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/yuv422_rgb_conv_tb.sv
module yuv422_rgb_conv_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  always #5 clk = ~clk;

  yuv422_rgb_conv u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // {Y0, U, Y1, V}
  localparam logic [31:0] VEC [0:7] = '{
    32'h1080EB80, 32'h0000FFFF, 32'h80808080, 32'h525A91F0,
    32'h29F0D26E, 32'hFF0000FF, 32'hC83C1EC8, 32'h64FF6400
  };

  int nchk = 0;
  int nfail = 0;
  int nexp = 0;
  int ngot = 0;
  int waits = 0;
  int bp_mode = 0;
  int cyc = 0;
  logic [23:0] expq [0:63];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input int x);
    if (x < 0) return 8'd0;
    if (x > 255) return 8'd255;
    return x[7:0];
  endfunction

  // R2 R3 R4: reference from the stated formula
  function automatic logic [23:0] conv(input int y, input int u, input int v);
    int c, d, e;
    c = y - 16; d = u - 128; e = v - 128;
    return {sat((298*c + 409*e + 128) >>> 8),
            sat((298*c - 100*d - 208*e + 128) >>> 8),
            sat((298*c + 516*d + 128) >>> 8)};
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    #1;
    while (!in_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R1: U word = {U, Y0}, V word = {V, Y1}
  task automatic send_pair(input logic [31:0] p);
    expq[nexp]   = conv(int'(p[31:24]), int'(p[23:16]), int'(p[7:0]));
    expq[nexp+1] = conv(int'(p[15:8]),  int'(p[23:16]), int'(p[7:0]));
    nexp += 2;
    send({p[23:16], p[31:24]});
    send({p[7:0],   p[15:8]});
  endtask

  task automatic drain;
    while (ngot < nexp) @(negedge clk);
    idle(6);
    check(ngot == nexp, "R6 pixel count", ngot, nexp);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // consumer: sets out_ready, compares accepted pixels, checks stalls
  initial begin
    bit prev_stall = 1'b0;
    logic [23:0] prev_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      #1;
      if (rst) begin
        ngot = 0;
        prev_stall = 1'b0;
      end else begin
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R6 stall hold",
                {7'd0, out_valid, out_data}, {8'd1, prev_data});
        if (out_valid && out_ready) begin
          if (ngot < nexp)
            check(out_data == expq[ngot], "R1 R2 R3 R4 pixel", out_data, expq[ngot]);
          else
            check(1'b0, "R6 extra pixel", out_data, 32'd0);
          ngot++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    #2000000;
    nfail++;
    $display("FAIL R6 watchdog: actual %0d pixels expected %0d", ngot, nexp);
    finish_up();
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R7 out_valid in reset", out_valid, 0);
    check(in_ready, "R7 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid, "R7 out_valid after reset", out_valid, 0);

    // R8: table at full rate, output always ready
    waits = 0;
    for (int i = 0; i < 8; i++) send_pair(VEC[i]);
    check(waits == 0, "R8 stall cycles at full rate", waits, 0);
    idle(1);
    drain();

    // R6: same table under back-pressure and input gaps
    bp_mode = 1;
    for (int i = 0; i < 8; i++) begin
      send_pair(VEC[7-i]);
      if (i % 2 == 1) idle(i);
    end
    idle(1);
    drain();
    bp_mode = 0;

    // R5: a lone U word yields no pixel
    send({8'h5A, 8'h52});
    idle(10);
    #1;
    check(!out_valid && ngot == nexp, "R5 no pixel before V word", out_valid, 0);
    expq[nexp]   = conv(8'h52, 8'h5A, 8'hF0);
    expq[nexp+1] = conv(8'h91, 8'h5A, 8'hF0);
    nexp += 2;
    send({8'hF0, 8'h91});
    idle(1);
    drain();

    // R7: a U word before reset is dropped; phase restarts at U
    send({8'h10, 8'h50});
    idle(1);
    rst = 1'b1;
    nexp = 0;
    idle(2);
    #1;
    check(!out_valid, "R7 out_valid mid reset", out_valid, 0);
    rst = 1'b0;
    send_pair(VEC[4]);
    send_pair(VEC[6]);
    idle(1);
    drain();

    finish_up();
  end
endmodule